// File: doc/BRIEF.md
# Bank Base/Size Address Decoder

This block keeps a small set of bank configuration registers and, every cycle, decides which bank (if any) claims a 32-bit physical address. Each register combines a base address, a three-bit power-of-two size code and an enable bit. Given an address, the decoder returns a hit flag, the index of the claiming bank and the offset of the address inside that bank.

Software-style access goes through a plain register port: one write per cycle to a selected bank and a combinational read of any bank. A separate load path programs one bank from a base and a byte size, converting the size into the code. A global enable input gates all matching, so the whole map can be switched off without disturbing the stored configuration.

Top module: `bank_addr_decoder`

## Requirements
- R1: After a synchronous active-low reset every bank register reads zero and no address hits.
- R2: A register write stores the written word ANDed with 0xFFDEE001 into the selected bank; the read port returns that stored value in the cycle after the write edge.
- R3: A bank covers 4 MiB shifted left by its size code (bits 19:17: 0 gives 4 MiB up to 6 giving 256 MiB); it matches when the address bits from bit 22+code upward equal the same bits of the register ANDed with 0xFF800000.
- R4: A bank whose size code is 7 never matches any address.
- R5: A bank can match only when its bit 0 is set and the global enable input is high.
- R6: When several banks match, the lowest-numbered one is reported.
- R7: On a hit the offset output is the address with every bit from 22+code upward cleared; with no hit the index and offset outputs are zero.
- R8: A load of a supported byte size (4 MiB to 256 MiB, powers of two) stores the matching code in bits 19:17, the base ANDed with 0xFF800000, and bit 0 set.
- R9: A load whose size is zero or not a supported power of two stores an all-zero word, leaving that bank disabled.
- R10: In a cycle where a load is requested, any register write in that cycle is ignored for every bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable for all bank matches |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 2 | Bank selected for the write |
| cfg_wr_data | input | 32 | Word to write (masked on storage) |
| cfg_rd_idx | input | 2 | Bank selected for reading |
| cfg_rd_data | output | 32 | Stored value of the selected bank |
| init_load | input | 1 | Load a bank from base and size |
| init_idx | input | 2 | Bank to load |
| init_base | input | 32 | Base address for the load |
| init_size | input | 32 | Byte size for the load |
| lookup_addr | input | 32 | Address to decode |
| hit | output | 1 | Some bank claims the address |
| hit_idx | output | 2 | Index of the claiming bank |
| hit_offset | output | 32 | Offset of the address inside that bank |

## Verification
The embedded assertions watch on every cycle that a hit never occurs with the global enable low, with the winning bank disabled or carrying the reserved size code, or while a lower bank also matches, that idle outputs are zero, and that writes and loads land in the register as masked. Whether the comparison uses the right number of upper bits, whether the offset is cut at the right bit, and whether the size-to-code conversion picks the correct code can only be shown by the bench, which runs a behavioural model of the register file and decode beside the design over directed overlap, reserved-code and unsupported-size scenarios and a random phase.

// File: rtl/bdec_pkg.sv
// Package: constants and the size-to-register encoder shared by the
// bank address decoder. Assumes 32-bit addresses and registers.
package bdec_pkg;
    localparam int unsigned REG_W     = 32;
    localparam logic [31:0] STORE_MASK = 32'hFFDEE001;
    localparam logic [31:0] BASE_MASK  = 32'hFF800000;
    localparam int unsigned CODE_LSB  = 17;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned MIN_SHIFT = 22;  // 4 MiB
    localparam int unsigned NUM_CODES = 7;   // codes 0..6 valid
    localparam logic [2:0]  CODE_BAD  = 3'd7;

    // Build a register word from a base and a byte size; zero if unsupported.
    function automatic logic [31:0] encode_bank(input logic [31:0] base,
                                                input logic [31:0] size);
        logic [31:0] word;
        word = '0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (size == (32'd1 << (MIN_SHIFT + c))) begin
                word = (32'(c) << CODE_LSB) | (base & BASE_MASK) | 32'd1;
            end
        end
        return word;
    endfunction
endpackage

// File: rtl/bdec_bank_reg.sv
// Module: one bank configuration register. A load takes precedence over
// a write; both are masked on storage. Assumes callers gate the strobes.
module bdec_bank_reg
    import bdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             init_en,
    input  logic [REG_W-1:0] init_data,
    output logic [REG_W-1:0] q
);
    // Store the load word, else the write word, masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (init_en) begin
            q <= init_data & STORE_MASK;
        end else if (wr_en) begin
            q <= wr_data & STORE_MASK;
        end
    end

    assert_write_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_en && !init_en) |-> q == ($past(wr_data) & STORE_MASK));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && init_en) |-> q == ($past(init_data) & STORE_MASK));
endmodule

// File: rtl/bdec_bank_match.sv
// Module: compares an address against one bank register and produces the
// in-bank offset. Purely combinational; reserved code 7 never matches.
module bdec_bank_match
    import bdec_pkg::*;
(
    input  logic [REG_W-1:0] bank_q,
    input  logic             glb_en,
    input  logic [REG_W-1:0] addr,
    output logic             match,
    output logic [REG_W-1:0] offset
);
    logic [CODE_W-1:0] code;
    logic [4:0]        shamt;
    logic [REG_W-1:0]  low_mask;

    // Derive the size window and compare the bits above it.
    always_comb begin
        code     = bank_q[CODE_LSB +: CODE_W];
        shamt    = 5'(MIN_SHIFT) + {2'b00, code};
        low_mask = (32'd1 << shamt) - 32'd1;
        offset   = addr & low_mask;
        match    = glb_en && bank_q[0] && (code != CODE_BAD) &&
                   ((addr & ~low_mask) == (bank_q & BASE_MASK & ~low_mask));
    end
endmodule

// File: rtl/bdec_prio_sel.sv
// Module: fixed-priority selector; the lowest-numbered matching bank
// wins. Outputs are zero when nothing matches.
module bdec_prio_sel #(
    parameter int unsigned NB    = 4,
    parameter int unsigned W     = 32,
    localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0]        match,
    input  logic [NB-1:0][W-1:0] offs,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [W-1:0]         offset
);
    // Scan from the top so the lowest match is written last.
    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        offset = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (match[b]) begin
                hit    = 1'b1;
                idx    = IDX_W'(b);
                offset = offs[b];
            end
        end
    end
endmodule

// File: rtl/bank_addr_decoder.sv
// Module: top of the bank decoder. Holds NB bank registers, a write/read
// register port, a base/size load path and the address decode.
// Assumes a load and a write in the same cycle resolve to the load only.
module bank_addr_decoder
    import bdec_pkg::*;
#(
    parameter int unsigned NB    = 4,
    localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             cfg_wr_en,
    input  logic [IDX_W-1:0] cfg_wr_idx,
    input  logic [31:0]      cfg_wr_data,
    input  logic [IDX_W-1:0] cfg_rd_idx,
    output logic [31:0]      cfg_rd_data,
    input  logic             init_load,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [31:0]      init_base,
    input  logic [31:0]      init_size,
    input  logic [31:0]      lookup_addr,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [31:0]      hit_offset
);
    logic [NB-1:0][REG_W-1:0] bank_q;
    logic [NB-1:0][REG_W-1:0] bank_off;
    logic [NB-1:0]            bank_match;
    logic [REG_W-1:0]         load_word;

    // Convert the load pair into a register word.
    always_comb load_word = encode_bank(init_base, init_size);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic sel_wr, sel_init;
        // Decode per-bank strobes; a load blocks every write.
        always_comb begin
            sel_init = init_load && (init_idx == IDX_W'(b));
            sel_wr   = cfg_wr_en && !init_load && (cfg_wr_idx == IDX_W'(b));
        end
        bdec_bank_reg u_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_en(sel_wr), .wr_data(cfg_wr_data),
            .init_en(sel_init), .init_data(load_word),
            .q(bank_q[b])
        );
        bdec_bank_match u_match (
            .bank_q(bank_q[b]), .glb_en(glb_en), .addr(lookup_addr),
            .match(bank_match[b]), .offset(bank_off[b])
        );
    end

    bdec_prio_sel #(.NB(NB), .W(REG_W)) u_sel (
        .match(bank_match), .offs(bank_off),
        .hit(hit), .idx(hit_idx), .offset(hit_offset)
    );

    // Return the stored word of the selected bank.
    always_comb cfg_rd_data = bank_q[cfg_rd_idx];

    assert_hit_needs_glb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> glb_en);

    assert_hit_bank_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> bank_q[hit_idx][0]);

    assert_no_reserved_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> bank_q[hit_idx][CODE_LSB +: CODE_W] != CODE_BAD);

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bank_match & ((NB'(1) << hit_idx) - NB'(1))) == '0);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0) && (hit_offset == '0));

    assert_offset_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_offset & ~lookup_addr) == '0);
endmodule

// File: tb/bank_addr_decoder_tb_top.sv
// Bench: behavioural reference model of the bank file and decode,
// compared against the design on every clock.
module bank_addr_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic        init_load = 1'b0;
    logic [1:0]  init_idx = '0;
    logic [31:0] init_base = '0;
    logic [31:0] init_size = '0;
    logic [31:0] lookup_addr = '0;
    logic        hit;
    logic [1:0]  hit_idx;
    logic [31:0] hit_offset;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [4];

    always #2.5 clk = ~clk;  // 200 MHz

    bank_addr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .init_load(init_load), .init_idx(init_idx),
        .init_base(init_base), .init_size(init_size),
        .lookup_addr(lookup_addr),
        .hit(hit), .hit_idx(hit_idx), .hit_offset(hit_offset)
    );

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_encode(input logic [31:0] b, input logic [31:0] s);
        logic [31:0] r;
        r = 32'h0;
        for (int k = 0; k < 7; k++)
            if (s == (32'h0040_0000 << k)) r = (32'(k) << 17) | (b & 32'hFF80_0000) | 32'h1;
        return r;
    endfunction

    // Compare outputs against the model, then advance one clock.
    task automatic tick();
        logic        e_hit;
        logic [1:0]  e_idx;
        logic [31:0] e_off;
        #1;
        e_hit = 1'b0; e_idx = 2'd0; e_off = 32'h0;
        if (rst_n) begin
            for (int b = 3; b >= 0; b--) begin
                longint unsigned sz;
                logic [31:0] hi;
                int code;
                code = int'(model[b][19:17]);
                if (glb_en && model[b][0] && code != 7) begin
                    sz = 64'd4194304 << code;
                    hi = ~(32'(sz - 1));
                    if ((lookup_addr & hi) == (model[b] & 32'hFF80_0000 & hi)) begin
                        e_hit = 1'b1; e_idx = 2'(b); e_off = lookup_addr & ~hi;
                    end
                end
            end
            expect32("R2 read port", cfg_rd_data, model[cfg_rd_idx]);
            expect32("R3 hit", {31'b0, hit}, {31'b0, e_hit});
            expect32("R6 index", {30'b0, hit_idx}, {30'b0, e_idx});
            expect32("R7 offset", hit_offset, e_off);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) model[b] = 32'h0;
        end else if (init_load) begin
            model[init_idx] = model_encode(init_base, init_size);
        end else if (cfg_wr_en) begin
            model[cfg_wr_idx] = cfg_wr_data & 32'hFFDE_E001;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_wr_en = 1'b0; init_load = 1'b0;
    endtask

    task automatic wr(input logic [1:0] i, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_idx = i; cfg_wr_data = d; tick(); idle();
    endtask

    task automatic ld(input logic [1:0] i, input logic [31:0] b, input logic [31:0] s);
        init_load = 1'b1; init_idx = i; init_base = b; init_size = s; tick(); idle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++) model[b] = 32'h0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1; glb_en = 1'b1;
        // R1: all registers zero, no hit after reset
        for (int b = 0; b < 4; b++) begin
            cfg_rd_idx = 2'(b); #1;
            expect32("R1 reset register", cfg_rd_data, 32'h0);
        end
        lookup_addr = 32'h0000_0000; #1;
        expect32("R1 reset no hit", {31'b0, hit}, 32'h0);
        tick();

        // R2 masking and R4 reserved code
        wr(2'd0, 32'hFFFF_FFFF);
        cfg_rd_idx = 2'd0; lookup_addr = 32'hFF80_0000; #1;
        expect32("R2 masked store", cfg_rd_data, 32'hFFDE_E001);
        expect32("R4 reserved never hits", {31'b0, hit}, 32'h0);
        tick();

        // R3/R7: 16 MiB bank at zero
        wr(2'd0, 32'h0004_0001);
        lookup_addr = 32'h00A0_1234; #1;
        expect32("R3 hit in 16 MiB", {31'b0, hit}, 32'h1);
        expect32("R7 offset in 16 MiB", hit_offset, 32'h00A0_1234);
        tick();
        lookup_addr = 32'h0100_0000; #1;
        expect32("R3 miss above 16 MiB", {31'b0, hit}, 32'h0);
        expect32("R7 idle offset zero", hit_offset, 32'h0);
        tick();

        // R5: global enable and bank enable
        glb_en = 1'b0; lookup_addr = 32'h00A0_1234; #1;
        expect32("R5 global enable gates", {31'b0, hit}, 32'h0);
        tick();
        glb_en = 1'b1;
        wr(2'd1, 32'h0100_0000);
        lookup_addr = 32'h0100_0010; #1;
        expect32("R5 bank bit0 clear", {31'b0, hit}, 32'h0);
        tick();

        // R6: overlap, lowest wins
        wr(2'd1, 32'h0000_0001);
        lookup_addr = 32'h0000_0040; #1;
        expect32("R6 lowest index wins", {30'b0, hit_idx}, 32'h0);
        tick();
        wr(2'd0, 32'h0);
        #1;
        expect32("R6 next bank after disable", {30'b0, hit_idx}, 32'h1);
        expect32("R7 offset 4 MiB", hit_offset, 32'h0000_0040);
        tick();

        // R8: load path
        ld(2'd2, 32'h2000_0000, 32'h0400_0000);
        cfg_rd_idx = 2'd2; lookup_addr = 32'h2345_6789; #1;
        expect32("R8 encoded word", cfg_rd_data, 32'h2008_0001);
        expect32("R8 loaded bank index", {30'b0, hit_idx}, 32'h2);
        expect32("R7 offset 64 MiB", hit_offset, 32'h0345_6789);
        tick();

        // R9: unsupported and zero sizes
        ld(2'd3, 32'h3000_0000, 32'h0030_0000);
        cfg_rd_idx = 2'd3; #1;
        expect32("R9 unsupported size", cfg_rd_data, 32'h0);
        tick();
        ld(2'd2, 32'h2000_0000, 32'h0);
        cfg_rd_idx = 2'd2; #1;
        expect32("R9 zero size", cfg_rd_data, 32'h0);
        expect32("R9 zero size no hit", {31'b0, hit}, 32'h0);
        tick();

        // R10: load and write together
        init_load = 1'b1; init_idx = 2'd1; init_base = 32'h4000_0000; init_size = 32'h0080_0000;
        cfg_wr_en = 1'b1; cfg_wr_idx = 2'd0; cfg_wr_data = 32'h0004_0001;
        tick(); idle();
        cfg_rd_idx = 2'd1; #1;
        expect32("R10 load stored", cfg_rd_data, 32'h4002_0001);
        cfg_rd_idx = 2'd0; #1;
        expect32("R10 write dropped", cfg_rd_data, 32'h0);
        tick();

        // Random phase against the model
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            glb_en      = (r < 90);
            cfg_wr_en   = ($urandom_range(0, 9) < 3);
            cfg_wr_idx  = 2'($urandom);
            cfg_wr_data = $urandom & 32'hFFFD_FFFF;
            init_load   = ($urandom_range(0, 9) == 0);
            init_idx    = 2'($urandom);
            init_base   = $urandom;
            init_size   = ($urandom_range(0, 3) == 0) ? $urandom
                          : (32'h0040_0000 << $urandom_range(0, 6));
            cfg_rd_idx  = 2'($urandom);
            lookup_addr = ($urandom_range(0, 1) == 0) ? $urandom
                          : ((model[2'($urandom)] & 32'hFF80_0000) | ($urandom & 32'h00FF_FFFF));
            tick();
        end
        idle();
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule